// File: doc/BRIEF.md
# I2C Event Flag and Status Register

This block sits between a two-wire bus engine and the software that drives it. The bus engine reports each event that needs software attention as one transfer on a valid/ready event port. The transfer carries an event kind and the acknowledge bit sampled from the bus. When the block accepts an event, it raises an interrupt flag. On the next clock it publishes an 8-bit status code for that event.

The flag stays set until software writes a clear. While the flag is set, the block holds the clock line low so that the bus stalls. The block also keeps a local acknowledge bit, which software writes through the control port. That bit is the value driven onto the bus when the block receives data, and it selects between two status codes for received data. For transmitted bytes, the status code reports whether the remote side acknowledged. The received acknowledge can be read only through the status code.

Back-pressure rules for the event port: `ev_ready` is high only while the flag is clear. A transfer happens on a rising edge where `ev_valid` and `ev_ready` are both high. While `ev_ready` is low, the source must keep `ev_kind` and `ev_ack_rx` stable and keep `ev_valid` high.

Top module: `i2c_evt_stat`

## Requirements
- R1: After reset, `int_flag` and `scl_hold` are 0, `ev_ready` is 1, `ack_drive` is 0 and `status` reads 8'hF8.
- R2: An accepted event sets `int_flag` on the same clock edge, and `scl_hold` is high exactly while `int_flag` is high.
- R3: In the first cycle `int_flag` is high, `status` still reads 8'hF8. From the second cycle until the flag clears, `status` shows the accepted event's code and does not change.
- R4: Whenever `int_flag` is low, `status` reads 8'hF8.
- R5: The low three bits of `status` are always 0.
- R6: `ev_ready` is low while `int_flag` is high. An event offered during that time is not taken and does not alter `status`. It is taken on the first edge after the flag clears.
- R7: A control write (`ctl_we`=1) with `ctl_clr_int`=1 clears `int_flag` on that edge. A control write with `ctl_clr_int`=0 leaves the flag as it is.
- R8: On every control write, the local acknowledge bit takes `ctl_ack` whatever `ctl_clr_int` is. `ack_drive` shows this bit from the next cycle.
- R9: Transmit events use `ev_ack_rx` (1 = acknowledged). Kind 1 (address with write sent) gives 8'h18 when acknowledged and 8'h20 when not. Kind 2 (data sent) gives 8'h28 when acknowledged and 8'h30 when not.
- R10: Kind 6 (data received) gives 8'h80 if `ack_drive` was 1 on the accepting edge, and 8'h88 if it was 0.
- R11: The other kinds give fixed codes: kind 0 (start sent) 8'h08, kind 3 (arbitration lost) 8'h38, kind 4 (own address received) 8'h60, kind 5 (general call received) 8'h70, and kind 7 (stop or repeated start received) 8'hA0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event transfer offered |
| ev_ready | output | 1 | Block can take an event (flag clear) |
| ev_kind | input | 3 | Event kind, encoding as in R9 to R11 |
| ev_ack_rx | input | 1 | Acknowledge sampled from the bus, 1 = acknowledged |
| ctl_we | input | 1 | Control write strobe |
| ctl_clr_int | input | 1 | With `ctl_we`, writing 1 clears the flag |
| ctl_ack | input | 1 | With `ctl_we`, new local acknowledge value |
| int_flag | output | 1 | Interrupt flag |
| status | output | 8 | Status code, 8'hF8 when no information |
| ack_drive | output | 1 | Acknowledge value driven when receiving |
| scl_hold | output | 1 | Hold clock line low |

## Verification
Some properties are checked on every cycle:
- `status` reads 8'hF8 while the flag is clear.
- The low three bits of `status` are zero.
- An accepted event sets the flag.
- The flag's first cycle shows 8'hF8.
- The code holds steady while the flag stays set.
- A clear write drops the flag.
- `ack_drive` follows each control write.

The bench's scenarios are needed to show the rest:
- Each event kind maps to the right code.
- The acknowledge qualifiers select between the paired codes.
- An event held off by back-pressure is taken only after the clear.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;
  localparam int ST_W   = 8;
  localparam int KIND_W = 3;
  localparam int LOW_Z  = 3;

  typedef enum logic [KIND_W-1:0] {
    EV_START    = 3'd0,
    EV_ADDR_TX  = 3'd1,
    EV_DATA_TX  = 3'd2,
    EV_ARB_LOST = 3'd3,
    EV_OWN_ADDR = 3'd4,
    EV_GEN_CALL = 3'd5,
    EV_DATA_RX  = 3'd6,
    EV_STOP_RX  = 3'd7
  } ev_kind_e;

  localparam logic [ST_W-1:0] ST_IDLE      = 8'hF8;
  localparam logic [ST_W-1:0] ST_START     = 8'h08;
  localparam logic [ST_W-1:0] ST_ADDR_ACK  = 8'h18;
  localparam logic [ST_W-1:0] ST_ADDR_NACK = 8'h20;
  localparam logic [ST_W-1:0] ST_DTX_ACK   = 8'h28;
  localparam logic [ST_W-1:0] ST_DTX_NACK  = 8'h30;
  localparam logic [ST_W-1:0] ST_ARB       = 8'h38;
  localparam logic [ST_W-1:0] ST_OWN       = 8'h60;
  localparam logic [ST_W-1:0] ST_GCALL     = 8'h70;
  localparam logic [ST_W-1:0] ST_DRX_ACK   = 8'h80;
  localparam logic [ST_W-1:0] ST_DRX_NACK  = 8'h88;
  localparam logic [ST_W-1:0] ST_STOP      = 8'hA0;
endpackage

// File: rtl/i2c_evt_encoder.sv
module i2c_evt_encoder
  import i2c_evt_pkg::*;
(
  input  ev_kind_e          kind,
  input  logic              ack_rx,
  input  logic              ack_local,
  output logic [ST_W-1:0]   code
);
  logic [ST_W-1:0] raw;

  always_comb begin
    case (kind)
      EV_START:    raw = ST_START;
      EV_ADDR_TX:  raw = ack_rx ? ST_ADDR_ACK : ST_ADDR_NACK;
      EV_DATA_TX:  raw = ack_rx ? ST_DTX_ACK : ST_DTX_NACK;
      EV_ARB_LOST: raw = ST_ARB;
      EV_OWN_ADDR: raw = ST_OWN;
      EV_GEN_CALL: raw = ST_GCALL;
      EV_DATA_RX:  raw = ack_local ? ST_DRX_ACK : ST_DRX_NACK;
      EV_STOP_RX:  raw = ST_STOP;
      default:     raw = ST_IDLE;
    endcase
  end

  // low bits of every code are reserved and forced to zero
  assign code = {raw[ST_W-1:LOW_Z], {LOW_Z{1'b0}}};
endmodule

// File: rtl/i2c_evt_flag.sv
module i2c_evt_flag
  import i2c_evt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  logic            clr,
  input  logic [ST_W-1:0] code_in,
  output logic            flag,
  output logic [ST_W-1:0] code_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag   <= 1'b0;
      code_q <= ST_IDLE;
    end else if (accept) begin
      flag   <= 1'b1;
      code_q <= code_in;
    end else if (clr) begin
      flag   <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_evt_status.sv
module i2c_evt_status
  import i2c_evt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flag,
  input  logic [ST_W-1:0] code_q,
  output logic [ST_W-1:0] status
);
  logic [ST_W-1:0] stat_q;

  // loads one edge after the flag rose, so the first flagged cycle shows idle
  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= ST_IDLE;
    else        stat_q <= flag ? code_q : ST_IDLE;
  end

  assign status = flag ? stat_q : ST_IDLE;
endmodule

// File: rtl/i2c_evt_stat.sv
module i2c_evt_stat
  import i2c_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [KIND_W-1:0] ev_kind,
  input  logic              ev_ack_rx,
  input  logic              ctl_we,
  input  logic              ctl_clr_int,
  input  logic              ctl_ack,
  output logic              int_flag,
  output logic [ST_W-1:0]   status,
  output logic              ack_drive,
  output logic              scl_hold
);
  logic            accept;
  logic [ST_W-1:0] ev_code;
  logic [ST_W-1:0] code_q;
  logic            ack_q;

  assign ev_ready = ~int_flag;
  assign accept   = ev_valid & ev_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)      ack_q <= 1'b0;
    else if (ctl_we) ack_q <= ctl_ack;
  end

  i2c_evt_encoder u_enc (
    .kind      (ev_kind_e'(ev_kind)),
    .ack_rx    (ev_ack_rx),
    .ack_local (ack_q),
    .code      (ev_code)
  );

  i2c_evt_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .clr     (ctl_we & ctl_clr_int),
    .code_in (ev_code),
    .flag    (int_flag),
    .code_q  (code_q)
  );

  i2c_evt_status u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .flag   (int_flag),
    .code_q (code_q),
    .status (status)
  );

  assign ack_drive = ack_q;
  assign scl_hold  = int_flag;
endmodule

// File: rtl/i2c_evt_stat_chk.sv
module i2c_evt_stat_chk
  import i2c_evt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ev_valid,
  input logic              ev_ready,
  input logic [KIND_W-1:0] ev_kind,
  input logic              ev_ack_rx,
  input logic              ctl_we,
  input logic              ctl_clr_int,
  input logic              ctl_ack,
  input logic              int_flag,
  input logic [ST_W-1:0]   status,
  input logic              ack_drive,
  input logic              scl_hold
);
  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    !int_flag |-> status == ST_IDLE); // R4
  AST_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    status[LOW_Z-1:0] == '0); // R5
  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_ready) |=> int_flag); // R2
  AST_FIRST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_flag) |-> status == ST_IDLE); // R3
  AST_CODE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (int_flag && $past(int_flag) && $past(int_flag, 2)) |-> $stable(status)); // R3
  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_clr_int && int_flag) |=> !int_flag); // R7
  AST_ACK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> ack_drive == $past(ctl_ack)); // R8
endmodule

bind i2c_evt_stat i2c_evt_stat_chk u_chk (.*);

// File: tb/i2c_evt_stat_tb.sv
module i2c_evt_stat_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev_valid = 1'b0;
  logic       ev_ready;
  logic [2:0] ev_kind = 3'd0;
  logic       ev_ack_rx = 1'b0;
  logic       ctl_we = 1'b0;
  logic       ctl_clr_int = 1'b0;
  logic       ctl_ack = 1'b0;
  logic       int_flag;
  logic [7:0] status;
  logic       ack_drive;
  logic       scl_hold;

  int n_chk = 0;
  int n_fail = 0;

  // reference model state
  bit         m_flag = 0;
  int         m_age = 0;
  bit [7:0]   m_code = 8'hF8;
  bit         m_ack = 0;

  always #2 clk = ~clk;

  i2c_evt_stat u_dut (.*);

  function automatic bit [7:0] exp_code(int kind, bit ackrx, bit ackl);
    case (kind)
      0: return 8'h08;
      1: return ackrx ? 8'h18 : 8'h20;
      2: return ackrx ? 8'h28 : 8'h30;
      3: return 8'h38;
      4: return 8'h60;
      5: return 8'h70;
      6: return ackl ? 8'h80 : 8'h88;
      default: return 8'hA0;
    endcase
  endfunction

  task automatic check(bit ok, string tag, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, expv, $time);
    end
  endtask

  // behavioural model advanced on each edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_flag <= 0; m_age <= 0; m_code <= 8'hF8; m_ack <= 0;
    end else begin
      if (ev_valid && !m_flag) begin
        m_flag <= 1; m_age <= 0;
        m_code <= exp_code(ev_kind, ev_ack_rx, m_ack);
      end else if (m_flag) begin
        if (ctl_we && ctl_clr_int) m_flag <= 0;
        else if (m_age < 4) m_age <= m_age + 1;
      end
      if (ctl_we) m_ack <= ctl_ack;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit [7:0] es;
      es = (m_flag && m_age >= 1) ? m_code : 8'hF8;
      check(int_flag == m_flag, "R2 flag", int_flag, m_flag);
      check(scl_hold == m_flag, "R2 hold", scl_hold, m_flag);
      check(ev_ready == !m_flag, "R6 ready", ev_ready, !m_flag);
      check(status == es, m_flag ? "R3 status" : "R4 status", status, es);
      check(status[2:0] == 3'b0, "R5 low bits", status[2:0], 0);
      check(ack_drive == m_ack, "R8 ack", ack_drive, m_ack);
    end
  end

  task automatic pulse_event(int kind, bit ackrx);
    @(negedge clk);
    ev_valid = 1; ev_kind = 3'(kind); ev_ack_rx = ackrx;
    @(negedge clk);
    ev_valid = 0;
  endtask

  task automatic ctl_write(bit clr, bit ack);
    @(negedge clk);
    ctl_we = 1; ctl_clr_int = clr; ctl_ack = ack;
    @(negedge clk);
    ctl_we = 0; ctl_clr_int = 0;
  endtask

  task automatic event_code(int kind, bit ackrx, bit [7:0] expv, string tag);
    pulse_event(kind, ackrx);
    check(status == 8'hF8, "R3 first flagged cycle", status, 8'hF8);
    @(negedge clk);
    check(status == expv, tag, status, expv);
    ctl_write(1, ack_drive);
    check(int_flag == 0, "R7 cleared", int_flag, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(int_flag == 0 && scl_hold == 0, "R1 flag/hold", int_flag, 0);
    check(ev_ready == 1, "R1 ready", ev_ready, 1);
    check(status == 8'hF8, "R1 status", status, 8'hF8);
    check(ack_drive == 0, "R1 ack", ack_drive, 0);
    rst_n = 1;
    @(negedge clk);
    check(status == 8'hF8, "R4 idle", status, 8'hF8);

    event_code(0, 0, 8'h08, "R11 start");
    event_code(1, 1, 8'h18, "R9 addr ack");
    event_code(1, 0, 8'h20, "R9 addr nack");
    event_code(2, 1, 8'h28, "R9 data ack");
    event_code(2, 0, 8'h30, "R9 data nack");
    event_code(3, 0, 8'h38, "R11 arb");
    event_code(4, 1, 8'h60, "R11 own");
    event_code(5, 0, 8'h70, "R11 gcall");
    event_code(7, 0, 8'hA0, "R11 stop");
    event_code(6, 0, 8'h88, "R10 rx nack");
    ctl_write(0, 1);
    check(ack_drive == 1, "R8 ack written", ack_drive, 1);
    event_code(6, 0, 8'h80, "R10 rx ack");

    // R7: a write without clear leaves the flag and still updates ack
    pulse_event(4, 0);
    ctl_write(0, 0);
    check(int_flag == 1, "R7 no clear", int_flag, 1);
    check(ack_drive == 0, "R8 ack with flag set", ack_drive, 0);
    check(status == 8'h60, "R7 code kept", status, 8'h60);

    // R6: held-off event does not disturb status, taken after clear
    @(negedge clk);
    ev_valid = 1; ev_kind = 3'd3; ev_ack_rx = 0;
    repeat (3) @(negedge clk);
    check(status == 8'h60, "R6 blocked event", status, 8'h60);
    check(ev_ready == 0, "R6 ready low", ev_ready, 0);
    ctl_we = 1; ctl_clr_int = 1;
    @(negedge clk);
    ctl_we = 0; ctl_clr_int = 0;
    check(int_flag == 0, "R7 clear", int_flag, 0);
    @(negedge clk);
    ev_valid = 0;
    check(int_flag == 1, "R6 taken after clear", int_flag, 1);
    @(negedge clk);
    check(status == 8'h38, "R6 late code", status, 8'h38);
    ctl_write(1, 0);

    // back-to-back events: clear and new event adjacent
    pulse_event(0, 0);
    ctl_write(1, 0);
    event_code(2, 1, 8'h28, "R9 after back-to-back");

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule